// File: doc/BRIEF.md
# Switch-Configurable PC Memory Decoder

This block turns the 20-bit memory space of an 8088-class bus into two chip selects: one for the on-board SRAM and one for the flash ROM. The CPU puts the address on a multiplexed bus while ALE is high. The block keeps the upper address bits in a register and decodes them whenever a memory read or write strobe is active. An eight-position configuration switch decides which of six 32 KiB upper-memory windows between 0xC0000 and 0xEFFFF are backed by RAM. The same switch sets whether the ROM occupies 64 KiB or 128 KiB at the top of memory.

The ROM's A16 pin is driven with the complement of the latched CPU A16. As a result, CPU addresses 0xF0000–0xFFFFF land in the ROM's lower 64 KiB and 0xE0000–0xEFFFF land in its upper 64 KiB. One switch position does not take part in decoding. It is passed out as a monitor-type status bit. Write strobes select the ROM in the same way as reads do, so the flash can be reprogrammed in place.

Top module: `memory_decoder`

## Requirements
- R1: The address register loads `cpu_addr_hi` (A19..A15) on every rising clock edge at which `ale` is 1. It holds its value while `ale` is 0, so bus changes during that time have no effect on `ram_sel`, `rom_sel` or `rom_a16`. A synchronous reset clears the register to zero.
- R2: Addresses 0x00000–0x9FFFF select RAM for every switch setting.
- R3: Addresses 0xA0000–0xBFFFF (display memory) assert neither `ram_sel` nor `rom_sel`.
- R4: 32 KiB block k (k = 0..5) starts at 0xC0000 + k·0x8000. It selects RAM when `cfg_sw[k]` is 1 (ON). Otherwise it selects nothing, except where R6 applies.
- R5: Addresses 0xF0000–0xFFFFF select the ROM for every switch setting.
- R6: When `cfg_sw[6]` is 0 (OFF), 0xE0000–0xEFFFF also selects the ROM, and the ROM select wins over `cfg_sw[4]`/`cfg_sw[5]`. When `cfg_sw[6]` is 1, the ROM window is only 0xF0000–0xFFFFF.
- R7: `rom_a16` always equals the complement of the latched A16, and it is 1 after reset.
- R8: `mono_disp` equals `cfg_sw[7]` (1 = monochrome, 0 = colour), and `cfg_sw[7]` has no effect on either select.
- R9: A select is driven only when `bus_io` is 0 (memory cycle) and `rd_n` or `wr_n` is 0. A write to the ROM window raises `rom_sel` just as a read does.
- R10: `ram_sel` and `rom_sel` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch enable from the CPU |
| cpu_addr_hi | input | 5 | CPU address bits A19..A15 from the multiplexed bus |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cfg_sw | input | 8 | Configuration switches; bit i is position i+1; 1 = ON |
| ram_sel | output | 1 | SRAM chip select, active high |
| rom_sel | output | 1 | Flash ROM chip select, active high |
| rom_a16 | output | 1 | ROM A16 pin, inverted CPU A16 |
| mono_disp | output | 1 | Display-type status, 1 = monochrome |

## Verification
The hardest case to reach is the interaction in the 0xE0000–0xEFFFF range. There, the ROM-size switch and the two upper-memory RAM switches compete for one address. A wrong priority shows up only for particular switch and address combinations. The bench reaches every one of them by sweeping all 256 switch vectors against the first and last address of every region and every 32 KiB block. It alternates reads and writes, and it always drives junk onto the address bus after ALE falls, so a latch that follows the bus would also be caught. Randomized accesses that mix I/O cycles and idle strobes then cover the qualification logic.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

    localparam int ADDR_W      = 20;
    localparam int BLK_LSB     = 15;
    localparam int HI_W        = ADDR_W - BLK_LSB;
    localparam int SW_W        = 8;

    // block numbers in units of 32 KiB
    localparam int DISP_FIRST  = 20;
    localparam int UMB_FIRST   = 24;
    localparam int NUM_UMB     = 6;
    localparam int EXT_FIRST   = 28;
    localparam int SYS_FIRST   = 30;

    localparam int ROM_SIZE_BIT = 6;
    localparam int MONO_BIT     = 7;
    localparam int A16_IDX      = 16 - BLK_LSB;

    typedef enum logic [1:0] {
        RG_BASE,
        RG_DISP,
        RG_UMB,
        RG_SYS
    } region_e;

    typedef struct packed {
        logic ram;
        logic rom;
    } dec_t;

    function automatic region_e region_of(input logic [HI_W-1:0] hi);
        if (int'(hi) < DISP_FIRST)     return RG_BASE;
        else if (int'(hi) < UMB_FIRST) return RG_DISP;
        else if (int'(hi) < SYS_FIRST) return RG_UMB;
        else                           return RG_SYS;
    endfunction

    function automatic logic in_ext(input logic [HI_W-1:0] hi);
        return (int'(hi) >= EXT_FIRST) && (int'(hi) < SYS_FIRST);
    endfunction

endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
    parameter int W = memdec_pkg::HI_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ale,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ale) q <= d;
    end
endmodule

// File: rtl/strobe_qual.sv
module strobe_qual (
    input  logic bus_io,
    input  logic rd_n,
    input  logic wr_n,
    output logic active
);
    always_comb active = !bus_io && (!rd_n || !wr_n);
endmodule

// File: rtl/region_decode.sv
module region_decode
    import memdec_pkg::*;
(
    input  logic [HI_W-1:0] hi,
    input  logic [SW_W-1:0] sw,
    output dec_t            dec
);
    logic [NUM_UMB-1:0] blk_hit;
    region_e            region;
    logic               rom_hit;

    for (genvar i = 0; i < NUM_UMB; i++) begin : g_umb
        assign blk_hit[i] = (hi == HI_W'(UMB_FIRST + i)) && sw[i];
    end

    always_comb begin
        region  = region_of(hi);
        rom_hit = (region == RG_SYS) || (in_ext(hi) && !sw[ROM_SIZE_BIT]);
        dec.rom = rom_hit;
        dec.ram = (region == RG_BASE) || ((|blk_hit) && !rom_hit);
    end
endmodule

// File: rtl/memory_decoder.sv
module memory_decoder
    import memdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ale,
    input  logic [HI_W-1:0] cpu_addr_hi,
    input  logic            bus_io,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [SW_W-1:0] cfg_sw,
    output logic            ram_sel,
    output logic            rom_sel,
    output logic            rom_a16,
    output logic            mono_disp
);
    logic [HI_W-1:0] addr_q;
    logic            active;
    dec_t            dec;

    addr_latch #(.W(HI_W)) u_latch (
        .clk (clk),
        .rst (rst),
        .ale (ale),
        .d   (cpu_addr_hi),
        .q   (addr_q)
    );

    strobe_qual u_qual (
        .bus_io (bus_io),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .active (active)
    );

    region_decode u_dec (
        .hi  (addr_q),
        .sw  (cfg_sw),
        .dec (dec)
    );

    always_comb begin
        ram_sel   = dec.ram && active;
        rom_sel   = dec.rom && active;
        rom_a16   = !addr_q[A16_IDX];
        mono_disp = cfg_sw[MONO_BIT];
    end
endmodule

// File: rtl/memory_decoder_chk.sv
module memory_decoder_chk
    import memdec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ale,
    input logic [HI_W-1:0] cpu_addr_hi,
    input logic            bus_io,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ram_sel,
    input logic            rom_sel,
    input logic            rom_a16
);
    // independent view of the captured address, built from the ports
    logic [HI_W-1:0] shadow;
    always_ff @(posedge clk) begin
        if (rst)      shadow <= '0;
        else if (ale) shadow <= cpu_addr_hi;
    end

    logic strobe;
    always_comb strobe = !bus_io && (!rd_n || !wr_n);

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(ram_sel && rom_sel));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> (!ram_sel && !rom_sel));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !ale |=> $stable(rom_a16));

    p_a16_r7: assert property (@(posedge clk) disable iff (rst)
        rom_a16 != shadow[A16_IDX]);

    p_disp_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(shadow) >= DISP_FIRST && int'(shadow) < UMB_FIRST) |-> (!ram_sel && !rom_sel));

    p_sys_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe && int'(shadow) >= SYS_FIRST) |-> rom_sel);

    p_base_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && int'(shadow) < DISP_FIRST) |-> ram_sel);
endmodule

bind memory_decoder memory_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ale         (ale),
    .cpu_addr_hi (cpu_addr_hi),
    .bus_io      (bus_io),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ram_sel     (ram_sel),
    .rom_sel     (rom_sel),
    .rom_a16     (rom_a16)
);

// File: tb/tb_memory_decoder.sv
module tb_memory_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic [4:0] cpu_addr_hi = '0;
    logic       bus_io = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] cfg_sw = '0;
    logic       ram_sel, rom_sel, rom_a16, mono_disp;

    int n_chk = 0;
    int n_err = 0;
    logic [19:0] cur_addr;
    logic [7:0]  cur_sw;

    always #2.5 clk = ~clk;

    memory_decoder dut (
        .clk(clk), .rst(rst), .ale(ale), .cpu_addr_hi(cpu_addr_hi),
        .bus_io(bus_io), .rd_n(rd_n), .wr_n(wr_n), .cfg_sw(cfg_sw),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .rom_a16(rom_a16),
        .mono_disp(mono_disp)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b addr=%h sw=%h", req, act, exp, cur_addr, cur_sw);
        end
    endtask

    function automatic string tag_of(logic [19:0] a, logic [7:0] sw);
        if (a < 20'hA0000) return "R2";
        if (a < 20'hC0000) return "R3";
        if (a < 20'hE0000) return "R4";
        if (a < 20'hF0000) return sw[6] ? "R4" : "R6";
        return "R5";
    endfunction

    function automatic logic exp_rom(logic [19:0] a, logic [7:0] sw, logic act);
        logic r;
        r = (a >= 20'hF0000) || (a >= 20'hE0000 && !sw[6]);
        return r && act;
    endfunction

    function automatic logic exp_ram(logic [19:0] a, logic [7:0] sw, logic act);
        logic r;
        int   k;
        r = (a < 20'hA0000);
        if (a >= 20'hC0000 && a < 20'hF0000) begin
            k = int'((a - 20'hC0000) >> 15);
            r = sw[k] && !((a >= 20'hE0000) && !sw[6]);
        end
        return r && act;
    endfunction

    task automatic access(logic [19:0] a, logic [7:0] sw, logic io, logic rdn, logic wrn, logic [4:0] junk);
        logic act;
        @(negedge clk);
        ale = 1'b1; cpu_addr_hi = a[19:15];
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        ale = 1'b0; cpu_addr_hi = junk;
        cfg_sw = sw; bus_io = io; rd_n = rdn; wr_n = wrn;
        cur_addr = a; cur_sw = sw;
        #1;
        act = !io && (!rdn || !wrn);
        chk(tag_of(a, sw), ram_sel, exp_ram(a, sw, act));
        chk(tag_of(a, sw), rom_sel, exp_rom(a, sw, act));
        chk("R7", rom_a16, !a[16]);
        chk("R8", mono_disp, sw[7]);
        chk("R10", ram_sel && rom_sel, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [19:0] bounds [18];
        void'($urandom(32'h1234_5eed));
        bounds = '{20'h00000, 20'h9FFFF, 20'hA0000, 20'hBFFFF,
                   20'hC0000, 20'hC7FFF, 20'hC8000, 20'hCFFFF,
                   20'hD0000, 20'hD7FFF, 20'hD8000, 20'hDFFFF,
                   20'hE0000, 20'hE7FFF, 20'hE8000, 20'hEFFFF,
                   20'hF0000, 20'hFFFFF};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        cur_addr = '0; cur_sw = '0;
        // reset state: no strobe, address register cleared
        chk("R9", ram_sel, 1'b0);
        chk("R9", rom_sel, 1'b0);
        chk("R7", rom_a16, 1'b1);

        // R1: latched address survives bus activity while ALE is low
        access(20'hF0000, 8'h00, 1'b0, 1'b0, 1'b1, 5'b00000);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cpu_addr_hi = 5'(i * 7);
            #1;
            chk("R1", rom_sel, 1'b1);
            chk("R1", ram_sel, 1'b0);
            chk("R1", rom_a16, 1'b0);
        end

        // R9: I/O cycles and idle strobes never select; ROM writes do
        access(20'h12345, 8'hFF, 1'b1, 1'b0, 1'b1, 5'h1F);
        chk("R9", ram_sel, 1'b0);
        access(20'hF8000, 8'hFF, 1'b0, 1'b1, 1'b1, 5'h00);
        chk("R9", rom_sel, 1'b0);
        access(20'hE8000, 8'h00, 1'b0, 1'b1, 1'b0, 5'h03);
        chk("R9", rom_sel, 1'b1);

        // sweep every switch vector over every region boundary
        for (int s = 0; s < 256; s++) begin
            for (int b = 0; b < 18; b++) begin
                access(bounds[b], 8'(s), 1'b0, b[0], !b[0], 5'($urandom));
            end
        end

        // randomized traffic
        for (int n = 0; n < 1500; n++) begin
            access(20'($urandom), 8'($urandom), ($urandom % 5) == 0,
                   1'($urandom), 1'($urandom), 5'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule